// File: doc/BRIEF.md
# Dual-Bank Flag Register with Branch Condition Evaluator

This block keeps the four status flags of a small 8/16-bit processor core: sign (S), zero (Z), a shared logical/overflow flag (LV) and carry (C). Two copies exist, a primary bank and an alternate bank. The execution unit sends flag results with a per-flag write mask and per-flag force-to-0 and force-to-1 bits. A bank-select bit routes each update to the alternate bank instead of the primary bank. A swap strobe exchanges the two banks in a single clock.

Branch logic presents a condition as a 2-bit format code and a 3-bit selector. The block returns one combinational bit that reports whether the condition holds, always judged from the primary bank. The LV flag serves two roles. For logic results it reads as "upper result bits nonzero". For arithmetic it reads as signed overflow. The signed comparisons combine it with S.

Flag vectors on the ports use bit 3 = S, bit 2 = Z, bit 1 = LV, bit 0 = C. This order applies to the mask, value, force and bank outputs alike.

Top module: `flag_cond_unit`

## Requirements
- R1: A synchronous active-high `rst` clears both banks to 4'b0000 at the next rising edge.
- R2: On an update (`upd_valid`=1), a flag whose mask, force-clear and force-set bits are all 0 keeps its old value. A flag whose mask bit is 1 and which has no force bit set takes the corresponding `upd_value` bit.
- R3: An update with `upd_alt`=1 writes only the alternate bank. An update with `upd_alt`=0 writes only the primary bank. The other bank is unchanged.
- R4: For each flag, force-set has priority over force-clear, and force-clear has priority over the masked value. A force bit writes its flag even when the mask bit for that flag is 0.
- R5: With `upd_valid`=0 and `swap`=0, neither bank changes.
- R6: A `swap` pulse exchanges the contents of the primary and alternate banks at the next edge.
- R7: When `swap` and an update occur in the same cycle, the update first lands in the bank that `upd_alt` names before the exchange, and then the two banks are exchanged.
- R8: With `cond_fmt`=00 (general), `cond_sel` decodes as 000 Z=0, 001 Z=1, 010 C=0, 011 C=1, 100 LV=0, 101 LV=1, 110 S=0, 111 S=1.
- R9: With `cond_fmt`=01 (short), `cond_sel[1:0]` decodes as 00 Z=0, 01 Z=1, 10 C=0, 11 C=1. `cond_sel[2]` is ignored.
- R10: With `cond_fmt`=10 (extended), `cond_sel[1:0]` decodes as follows, and `cond_sel[2]` is ignored:
  - 00: signed greater-than, (Z | (S ^ LV)) == 0
  - 01: unsigned greater-than, C == 0 and Z == 0
  - 10: signed less-than, S ^ LV == 1
  - 11: overflow, LV == 1
- R11: With `cond_fmt`=11 (reserved), `cond_true` is 0.
- R12: `cond_true` depends only on the primary bank. Writing the alternate bank does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Flag update strobe |
| upd_alt | input | 1 | 1 routes the update to the alternate bank |
| upd_mask | input | 4 | Per-flag write enable for `upd_value` |
| upd_value | input | 4 | New flag values |
| upd_force_clr | input | 4 | Per-flag force to 0 |
| upd_force_set | input | 4 | Per-flag force to 1 (wins over clear) |
| swap | input | 1 | Exchange the two banks |
| cond_fmt | input | 2 | Condition format: 00 general, 01 short, 10 extended, 11 reserved |
| cond_sel | input | 3 | Condition selector within the format |
| cond_true | output | 1 | Selected condition holds on the primary bank |
| flags_pri | output | 4 | Primary bank {S,Z,LV,C} |
| flags_alt | output | 4 | Alternate bank {S,Z,LV,C} |

## Verification
An update and a bank swap can fall in the same cycle. The ordering between them is the part that is easiest to get wrong.

The random stream raises `swap` on about a quarter of the cycles, and these are drawn independently of updates to either bank. Directed cycles force the case of an alternate-bank update combined with a swap.

Each such cycle is judged by comparing both bank outputs against a bench model that applies the update before the exchange. The condition bit is checked in the same cycle against the new primary bank.

// File: rtl/flagcond_pkg.sv
package flagcond_pkg;

    localparam int FLAG_W = 4;
    localparam int FLAG_S  = 3;
    localparam int FLAG_Z  = 2;
    localparam int FLAG_LV = 1;
    localparam int FLAG_C  = 0;

    typedef enum logic [1:0] {
        FMT_GENERAL  = 2'b00,
        FMT_SHORT    = 2'b01,
        FMT_EXTENDED = 2'b10,
        FMT_RESERVED = 2'b11
    } cond_fmt_e;

    typedef struct packed {
        logic s;
        logic z;
        logic lv;
        logic c;
    } flags_t;

endpackage

// File: rtl/flag_merge.sv
module flag_merge #(
    parameter int W = 4
) (
    input  logic         en,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] value,
    input  logic [W-1:0] force_clr,
    input  logic [W-1:0] force_set,
    output logic [W-1:0] nxt
);
    always_comb begin
        for (int i = 0; i < W; i++) begin
            if (!en)              nxt[i] = cur[i];
            else if (force_set[i]) nxt[i] = 1'b1;
            else if (force_clr[i]) nxt[i] = 1'b0;
            else if (mask[i])      nxt[i] = value[i];
            else                   nxt[i] = cur[i];
        end
    end
endmodule

// File: rtl/flag_bank_store.sv
module flag_bank_store #(
    parameter int W      = 4,
    parameter int NBANKS = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         upd_valid,
    input  logic         upd_alt,
    input  logic [W-1:0] upd_mask,
    input  logic [W-1:0] upd_value,
    input  logic [W-1:0] upd_force_clr,
    input  logic [W-1:0] upd_force_set,
    input  logic         swap,
    output logic [W-1:0] pri_flags,
    output logic [W-1:0] alt_flags
);
    localparam int IDX_PRI = 0;
    localparam int IDX_ALT = NBANKS - 1;

    typedef struct packed {
        logic [W-1:0] pri;
        logic [W-1:0] alt;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [W-1:0] cur_b [NBANKS];
    logic [W-1:0] mrg_b [NBANKS];
    logic         en_b  [NBANKS];

    assign cur_b[IDX_PRI] = st_q.pri;
    assign cur_b[IDX_ALT] = st_q.alt;

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        assign en_b[b] = upd_valid && (upd_alt == (b == IDX_ALT));
        flag_merge #(.W(W)) i_merge (
            .en        (en_b[b]),
            .cur       (cur_b[b]),
            .mask      (upd_mask),
            .value     (upd_value),
            .force_clr (upd_force_clr),
            .force_set (upd_force_set),
            .nxt       (mrg_b[b])
        );
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (swap) begin
            st_d.pri = mrg_b[IDX_ALT];
            st_d.alt = mrg_b[IDX_PRI];
        end else begin
            st_d.pri = mrg_b[IDX_PRI];
            st_d.alt = mrg_b[IDX_ALT];
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pri_flags = st_q.pri;
    assign alt_flags = st_q.alt;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pri_flags == '0 && alt_flags == '0));

    a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!upd_valid && !swap) |=> (pri_flags == $past(pri_flags) && alt_flags == $past(alt_flags)));

    a_r6_swap_exchanges: assert property (@(posedge clk) disable iff (rst)
        (swap && !upd_valid) |=> (pri_flags == $past(alt_flags) && alt_flags == $past(pri_flags)));

    a_r3_alt_spares_primary: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_alt && !swap) |=> (pri_flags == $past(pri_flags)));

    a_r3_pri_spares_alternate: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_alt && !swap) |=> (alt_flags == $past(alt_flags)));
endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import flagcond_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_W-1:0] flags,
    input  logic [1:0]        fmt,
    input  logic [2:0]        sel,
    output logic              cond_true
);
    flags_t f;
    logic   gen_r, shr_r, ext_r;
    logic   signed_lt;

    assign f         = flags_t'(flags);
    assign signed_lt = f.s ^ f.lv;

    always_comb begin
        case (sel)
            3'b000:  gen_r = !f.z;
            3'b001:  gen_r = f.z;
            3'b010:  gen_r = !f.c;
            3'b011:  gen_r = f.c;
            3'b100:  gen_r = !f.lv;
            3'b101:  gen_r = f.lv;
            3'b110:  gen_r = !f.s;
            default: gen_r = f.s;
        endcase
    end

    always_comb begin
        unique case (sel[1:0])
            2'b00:   shr_r = (f.z == 1'b0);
            2'b01:   shr_r = (f.z == 1'b1);
            2'b10:   shr_r = (f.c == 1'b0);
            default: shr_r = (f.c == 1'b1);
        endcase
    end

    always_comb begin
        unique case (sel[1:0])
            2'b00:   ext_r = !(f.z || signed_lt);
            2'b01:   ext_r = !f.c && !f.z;
            2'b10:   ext_r = signed_lt;
            default: ext_r = f.lv;
        endcase
    end

    always_comb begin
        case (cond_fmt_e'(fmt))
            FMT_GENERAL:  cond_true = gen_r;
            FMT_SHORT:    cond_true = shr_r;
            FMT_EXTENDED: cond_true = ext_r;
            default:      cond_true = 1'b0;
        endcase
    end

    a_r9_short_matches_general: assert property (@(posedge clk) disable iff (rst)
        (fmt == FMT_SHORT && !sel[2]) |-> (cond_true == gen_r));

    a_r11_reserved_false: assert property (@(posedge clk) disable iff (rst)
        (fmt == FMT_RESERVED) |-> !cond_true);

    a_r10_gt_excludes_zero: assert property (@(posedge clk) disable iff (rst)
        (fmt == FMT_EXTENDED && sel[1:0] == 2'b00 && cond_true) |-> !flags[FLAG_Z]);

    a_r10_gtu_excludes_carry: assert property (@(posedge clk) disable iff (rst)
        (fmt == FMT_EXTENDED && sel[1:0] == 2'b01 && cond_true) |-> !flags[FLAG_C]);
endmodule

// File: rtl/flag_cond_unit.sv
module flag_cond_unit
    import flagcond_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_valid,
    input  logic              upd_alt,
    input  logic [FLAG_W-1:0] upd_mask,
    input  logic [FLAG_W-1:0] upd_value,
    input  logic [FLAG_W-1:0] upd_force_clr,
    input  logic [FLAG_W-1:0] upd_force_set,
    input  logic              swap,
    input  logic [1:0]        cond_fmt,
    input  logic [2:0]        cond_sel,
    output logic              cond_true,
    output logic [FLAG_W-1:0] flags_pri,
    output logic [FLAG_W-1:0] flags_alt
);
    localparam int NBANKS = 2;

    logic [FLAG_W-1:0] pri_w, alt_w;

    flag_bank_store #(.W(FLAG_W), .NBANKS(NBANKS)) i_store (
        .clk           (clk),
        .rst           (rst),
        .upd_valid     (upd_valid),
        .upd_alt       (upd_alt),
        .upd_mask      (upd_mask),
        .upd_value     (upd_value),
        .upd_force_clr (upd_force_clr),
        .upd_force_set (upd_force_set),
        .swap          (swap),
        .pri_flags     (pri_w),
        .alt_flags     (alt_w)
    );

    cond_eval i_eval (
        .clk       (clk),
        .rst       (rst),
        .flags     (pri_w),
        .fmt       (cond_fmt),
        .sel       (cond_sel),
        .cond_true (cond_true)
    );

    assign flags_pri = pri_w;
    assign flags_alt = alt_w;
endmodule

// File: tb/test_flag_cond_unit.sv
module test_flag_cond_unit;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       upd_valid = 1'b0, upd_alt = 1'b0, swap = 1'b0;
    logic [3:0] upd_mask = '0, upd_value = '0, upd_force_clr = '0, upd_force_set = '0;
    logic [1:0] cond_fmt = '0;
    logic [2:0] cond_sel = '0;
    logic       cond_true;
    logic [3:0] flags_pri, flags_alt;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [3:0] m_pri = '0, m_alt = '0;

    always #2.5 clk = ~clk;

    flag_cond_unit i_flag_cond_unit (
        .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_alt(upd_alt),
        .upd_mask(upd_mask), .upd_value(upd_value), .upd_force_clr(upd_force_clr),
        .upd_force_set(upd_force_set), .swap(swap), .cond_fmt(cond_fmt),
        .cond_sel(cond_sel), .cond_true(cond_true), .flags_pri(flags_pri),
        .flags_alt(flags_alt)
    );

    function automatic logic [3:0] merge_f(logic [3:0] cur, logic [3:0] m, logic [3:0] v,
                                           logic [3:0] fc, logic [3:0] fs);
        logic [3:0] r;
        for (int i = 0; i < 4; i++)
            r[i] = fs[i] ? 1'b1 : fc[i] ? 1'b0 : m[i] ? v[i] : cur[i];
        return r;
    endfunction

    // flags {S,Z,LV,C}
    function automatic logic eval_f(logic [3:0] fl, logic [1:0] fmt, logic [2:0] sel);
        logic s, z, lv, c;
        {s, z, lv, c} = fl;
        case (fmt)
            2'd0: case (sel)
                3'd0: return !z;  3'd1: return z;  3'd2: return !c; 3'd3: return c;
                3'd4: return !lv; 3'd5: return lv; 3'd6: return !s; default: return s;
            endcase
            2'd1: case (sel[1:0])
                2'd0: return !z; 2'd1: return z; 2'd2: return !c; default: return c;
            endcase
            2'd2: case (sel[1:0])
                2'd0: return !(z | (s ^ lv));
                2'd1: return !c & !z;
                2'd2: return s ^ lv;
                default: return lv;
            endcase
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic string cond_req(logic [1:0] fmt);
        case (fmt)
            2'd0: return "R8 general condition";
            2'd1: return "R9 short condition";
            2'd2: return "R10 extended condition";
            default: return "R11 reserved format";
        endcase
    endfunction

    // drive at negedge, clock, check at next negedge
    task automatic step(logic v, logic a, logic [3:0] m, logic [3:0] val, logic [3:0] fc,
                        logic [3:0] fs, logic sw, logic [1:0] fmt, logic [2:0] sel, string freq);
        logic [3:0] np, na;
        upd_valid = v; upd_alt = a; upd_mask = m; upd_value = val;
        upd_force_clr = fc; upd_force_set = fs; swap = sw; cond_fmt = fmt; cond_sel = sel;
        np = (v && !a) ? merge_f(m_pri, m, val, fc, fs) : m_pri;
        na = (v && a)  ? merge_f(m_alt, m, val, fc, fs) : m_alt;
        if (sw) begin m_pri = na; m_alt = np; end
        else    begin m_pri = np; m_alt = na; end
        @(posedge clk);
        @(negedge clk);
        upd_valid = 1'b0; swap = 1'b0;
        chk({freq, " primary"}, flags_pri, m_pri);
        chk({freq, " alternate"}, flags_alt, m_alt);
        chk(cond_req(fmt), {3'b0, cond_true}, {3'b0, eval_f(m_pri, fmt, sel)});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd4711);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset primary", flags_pri, 4'h0);
        chk("R1 reset alternate", flags_alt, 4'h0);
        cond_fmt = 2'd1; cond_sel = 3'd0;
        #0.5;
        chk("R1 reset NZ true", {3'b0, cond_true}, 4'h1);
        rst = 1'b0;

        // R2 masked write of primary
        step(1, 0, 4'b1010, 4'b1111, 4'h0, 4'h0, 0, 2'd0, 3'd7, "R2 mask");
        // R4 force priority, force acts with mask 0
        step(1, 0, 4'b0000, 4'b0000, 4'b0101, 4'b0100, 0, 2'd0, 3'd1, "R4 force");
        // R3/R12 alternate update does not affect condition
        step(1, 1, 4'b1111, 4'b1111, 4'h0, 4'h0, 0, 2'd2, 3'd3, "R3 R12 alt write");
        // R5 idle
        step(0, 0, 4'b1111, 4'b0000, 4'hF, 4'h0, 0, 2'd3, 3'd0, "R5 idle");
        // R6 swap
        step(0, 0, 4'h0, 4'h0, 4'h0, 4'h0, 1, 2'd0, 3'd5, "R6 swap");
        // R7 swap with alternate update in same cycle
        step(1, 1, 4'b1111, 4'b0110, 4'h0, 4'h0, 1, 2'd2, 3'd0, "R7 swap+alt");
        // R7 swap with primary update
        step(1, 0, 4'b0011, 4'b0001, 4'h0, 4'h0, 1, 2'd1, 3'd6, "R7 swap+pri");
        // R10 corners: S=1 LV=1 -> GT true; S=1 LV=0 -> LT true
        step(1, 0, 4'b1111, 4'b1010, 4'h0, 4'h0, 0, 2'd2, 3'd0, "R10 setup gt");
        step(1, 0, 4'b1111, 4'b1000, 4'h0, 4'h0, 0, 2'd2, 3'd6, "R10 setup lt");
        step(1, 0, 4'b1111, 4'b0000, 4'h0, 4'h0, 0, 2'd2, 3'd1, "R10 setup gtu");

        for (int k = 0; k < 3000; k++) begin
            logic v, a, sw;
            string fr;
            v  = ($urandom % 3) != 0;
            a  = $urandom % 2;
            sw = ($urandom % 4) == 0;
            if (v && sw)     fr = "R7 random";
            else if (sw)     fr = "R6 random";
            else if (!v)     fr = "R5 random";
            else if (a)      fr = "R3 random";
            else             fr = "R2 R4 random";
            step(v, a, 4'($urandom), 4'($urandom), 4'($urandom & $urandom),
                 4'($urandom & $urandom & $urandom), sw, 2'($urandom), 3'($urandom), fr);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule